// File: doc/BRIEF.md
# Verify-and-Retry Resistive Cell Programmer

This controller drives the write stage of a ROWS×COLS resistive synapse array. A run begins on `start`. The controller then visits every cell in turn. For each cell it reads back the present conductance code and compares it with a stored target code.

When the reading is outside the tolerance window, the controller works out a direction and a number of identical programming pulses from a nominal per-pulse step size. It fires that burst, reads the cell again, and repeats until the cell is in tolerance or the retry budget runs out.

The selected cell is addressed by driving its row and column lines to the full programming level. Every other line is held at the half level, which stays below the device switching threshold. Between bursts and outside a run, all lines rest at the off code, so array reads use only small, non-disturbing voltages.

Target codes are loaded through a simple write port while the controller is idle. The per-pulse step size is an input that can be set for each run.

Top module: `cell_programmer`

## Requirements
- R1: After reset, `busy`, `done`, `err`, `rd_req` and `pulse_fire` are 0 and every line drive code is off.
- R2: Line drive codes are 2 bits each: 0 = off, 1 = half level, 2 = full level. Row i uses bits [2i+1:2i] of `row_drv` and column j uses the same bits of `col_drv`. While `pulse_fire` is high, the addressed row and column are at full level and every other line is at half level, so only the addressed cell changes. While `pulse_fire` is low, all lines are off.
- R3: Cells are visited one at a time in row-major order (cell index = row×COLS + col, starting at 0). Each visit begins with a read of that cell.
- R4: A burst raises conductance (`pulse_pos` = 1) when the target is above the reading, and lowers it otherwise. The burst length is floor(|target − reading| / step) with a minimum of 1, and a step input of 0 counts as 1. The pulses fire on consecutive cycles, with polarity and address held steady.
- R5: A reading within ±TOL (TOL = 1) of the target produces no pulses, and the controller moves on to the next cell.
- R6: After every burst the cell is read again. At most MAX_TRIES (8) bursts are spent on one cell. If the cell is still out of tolerance after the last burst, `err` is set and the next cell is taken. `err` stays set until the next `start`.
- R7: No pulse fires outside a run, and none fires while a read request is being issued.
- R8: `done` is high for exactly one cycle after the last cell is finished, and `busy` falls in that same cycle.
- R9: `start` has no effect while a run is in progress.
- R10: Target codes are written through `tgt_we`/`tgt_addr`/`tgt_data` while idle, using the row-major cell index as the address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a write run |
| step_size | input | CW | Nominal conductance change per pulse |
| tgt_we | input | 1 | Target write enable (idle only) |
| tgt_addr | input | AW | Target cell index |
| tgt_data | input | CW | Target conductance code |
| rd_valid | input | 1 | Read-back data valid |
| rd_data | input | CW | Read-back conductance code |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run strobe |
| err | output | 1 | Some cell exhausted its retry budget |
| rd_req | output | 1 | Read request for the addressed cell |
| cur_row | output | RW | Addressed row |
| cur_col | output | CLW | Addressed column |
| pulse_fire | output | 1 | Programming pulse active |
| pulse_pos | output | 1 | 1 = potentiate, 0 = depress |
| row_drv | output | 2*ROWS | Per-row drive codes |
| col_drv | output | 2*COLS | Per-column drive codes |

## Verification
The bench builds the block with a 2×3 array, 8-bit codes, a tolerance of 1 and a retry budget of 8. This keeps every cell's expected pulse count and read count small enough to work out by hand. With a behavioural device that moves 4 codes per pulse, a step input that matches the device gives single bursts. An oversized step input forces several shrinking bursts on one cell. A stuck cell uses up the full retry budget, and a zero step input exercises the minimum-divisor rule. A monitor checks the half-select pattern on every pulse cycle.

// File: rtl/cp_pkg.sv
package cp_pkg;
  typedef enum logic [1:0] {
    DRV_OFF  = 2'd0,
    DRV_HALF = 2'd1,
    DRV_FULL = 2'd2
  } drv_t;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_READ, S_WAIT, S_EVAL, S_PULSE, S_NEXT
  } st_t;
endpackage

// File: rtl/target_ram.sv
module target_ram #(
  parameter int DEPTH = 16,
  parameter int AW    = 4,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/pulse_predictor.sv
module pulse_predictor #(
  parameter int CW  = 8,
  parameter int TOL = 1
) (
  input  logic [CW-1:0] target,
  input  logic [CW-1:0] reading,
  input  logic [CW-1:0] step,
  output logic          in_tol,
  output logic          raise,
  output logic [CW-1:0] count
);
  logic [CW-1:0] diff, stp, quo;

  always_comb begin
    raise  = target > reading;
    diff   = raise ? (target - reading) : (reading - target);
    stp    = (step == '0) ? CW'(1) : step;
    quo    = diff / stp;
    in_tol = diff <= CW'(TOL);
    count  = (quo == '0) ? CW'(1) : quo;
  end
endmodule

// File: rtl/line_driver.sv
module line_driver import cp_pkg::*; #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic          active,
  input  logic [IW-1:0] sel,
  output logic [2*N-1:0] codes
);
  for (genvar i = 0; i < N; i++) begin : g_line
    assign codes[2*i +: 2] = !active ? DRV_OFF :
                             (sel == IW'(i)) ? DRV_FULL : DRV_HALF;
  end
endmodule

// File: rtl/cell_programmer.sv
module cell_programmer import cp_pkg::*; #(
  parameter int ROWS      = 4,
  parameter int COLS      = 4,
  parameter int CW        = 8,
  parameter int TOL       = 1,
  parameter int MAX_TRIES = 8,
  parameter int AW        = (ROWS*COLS > 1) ? $clog2(ROWS*COLS) : 1,
  parameter int RW        = (ROWS > 1) ? $clog2(ROWS) : 1,
  parameter int CLW       = (COLS > 1) ? $clog2(COLS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [CW-1:0]     step_size,
  input  logic              tgt_we,
  input  logic [AW-1:0]     tgt_addr,
  input  logic [CW-1:0]     tgt_data,
  input  logic              rd_valid,
  input  logic [CW-1:0]     rd_data,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              rd_req,
  output logic [RW-1:0]     cur_row,
  output logic [CLW-1:0]    cur_col,
  output logic              pulse_fire,
  output logic              pulse_pos,
  output logic [2*ROWS-1:0] row_drv,
  output logic [2*COLS-1:0] col_drv
);
  localparam int NCELL = ROWS * COLS;
  localparam int TW    = $clog2(MAX_TRIES + 1);

  st_t           state;
  logic [AW-1:0] idx;
  logic [CW-1:0] tgt_q, tgt_r, cur_r, pcnt, pred_cnt;
  logic [TW-1:0] tries;
  logic          pred_tol, pred_up;

  target_ram #(.DEPTH(NCELL), .AW(AW), .DW(CW)) u_tgt (
    .clk(clk), .we(tgt_we && !busy), .waddr(tgt_addr), .wdata(tgt_data),
    .raddr(idx), .rdata(tgt_q)
  );

  pulse_predictor #(.CW(CW), .TOL(TOL)) u_pred (
    .target(tgt_r), .reading(cur_r), .step(step_size),
    .in_tol(pred_tol), .raise(pred_up), .count(pred_cnt)
  );

  line_driver #(.N(ROWS), .IW(RW)) u_rows (
    .active(pulse_fire), .sel(cur_row), .codes(row_drv)
  );

  line_driver #(.N(COLS), .IW(CLW)) u_cols (
    .active(pulse_fire), .sel(cur_col), .codes(col_drv)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      idx        <= '0;
      cur_row    <= '0;
      cur_col    <= '0;
      tgt_r      <= '0;
      cur_r      <= '0;
      pcnt       <= '0;
      tries      <= '0;
      busy       <= 1'b0;
      done       <= 1'b0;
      err        <= 1'b0;
      rd_req     <= 1'b0;
      pulse_fire <= 1'b0;
      pulse_pos  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          idx     <= '0;
          cur_row <= '0;
          cur_col <= '0;
          err     <= 1'b0;
          busy    <= 1'b1;
          state   <= S_FETCH;
        end
        S_FETCH: begin
          tries <= '0;
          state <= S_READ;
        end
        S_READ: begin
          tgt_r  <= tgt_q;
          rd_req <= 1'b1;
          state  <= S_WAIT;
        end
        S_WAIT: begin
          rd_req <= 1'b0;
          if (rd_valid) begin
            cur_r <= rd_data;
            state <= S_EVAL;
          end
        end
        S_EVAL: begin
          if (pred_tol) begin
            state <= S_NEXT;
          end else if (tries == TW'(MAX_TRIES)) begin
            err   <= 1'b1;
            state <= S_NEXT;
          end else begin
            tries      <= tries + 1'b1;
            pcnt       <= pred_cnt;
            pulse_pos  <= pred_up;
            pulse_fire <= 1'b1;
            state      <= S_PULSE;
          end
        end
        S_PULSE: begin
          pcnt <= pcnt - 1'b1;
          if (pcnt == CW'(1)) begin
            pulse_fire <= 1'b0;
            state      <= S_READ;
          end
        end
        S_NEXT: begin
          if (idx == AW'(NCELL - 1)) begin
            busy  <= 1'b0;
            done  <= 1'b1;
            state <= S_IDLE;
          end else begin
            idx <= idx + 1'b1;
            if (cur_col == CLW'(COLS - 1)) begin
              cur_col <= '0;
              cur_row <= cur_row + 1'b1;
            end else begin
              cur_col <= cur_col + 1'b1;
            end
            state <= S_FETCH;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R7: pulse generator silent outside a run and during read requests
  a_r7_quiet_idle: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !pulse_fire);
  a_r7_no_pulse_on_read: assert property (@(posedge clk) disable iff (rst)
    rd_req |-> !pulse_fire);
  // R6: retry budget is never exceeded
  a_r6_try_bound: assert property (@(posedge clk) disable iff (rst)
    busy |-> tries <= TW'(MAX_TRIES));
  // R4: burst keeps polarity and address steady
  a_r4_burst_steady: assert property (@(posedge clk) disable iff (rst)
    (pulse_fire && $past(pulse_fire)) |->
      ($stable(pulse_pos) && $stable(cur_row) && $stable(cur_col)));
  // R2: selected row stays inside the array
  a_r2_row_in_range: assert property (@(posedge clk) disable iff (rst)
    pulse_fire |-> (int'(cur_row) < ROWS && int'(cur_col) < COLS));
  // R8: done is a single-cycle strobe that ends the run
  a_r8_done_once: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r8_done_ends_run: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));
endmodule

// File: tb/sim_cell_programmer.sv
`timescale 1ns/1ps
module sim_cell_programmer;
  localparam int R = 2, C = 3, N = R*C, W = 8;
  localparam int AW = 3, RWB = 1, CWB = 2;

  logic clk = 0, rst = 1, start = 0, tgt_we = 0, rd_valid = 0;
  logic [W-1:0] step_size = 0, tgt_data = 0, rd_data = 0;
  logic [AW-1:0] tgt_addr = 0;
  logic busy, done, err, rd_req, pulse_fire, pulse_pos;
  logic [RWB-1:0] cur_row;
  logic [CWB-1:0] cur_col;
  logic [2*R-1:0] row_drv;
  logic [2*C-1:0] col_drv;

  always #5 clk = ~clk;

  cell_programmer #(.ROWS(R), .COLS(C), .CW(W), .TOL(1), .MAX_TRIES(8)) u0 (
    .clk(clk), .rst(rst), .start(start), .step_size(step_size),
    .tgt_we(tgt_we), .tgt_addr(tgt_addr), .tgt_data(tgt_data),
    .rd_valid(rd_valid), .rd_data(rd_data), .busy(busy), .done(done),
    .err(err), .rd_req(rd_req), .cur_row(cur_row), .cur_col(cur_col),
    .pulse_fire(pulse_fire), .pulse_pos(pulse_pos),
    .row_drv(row_drv), .col_drv(col_drv));

  int checks = 0, fails = 0;
  int g[N];
  bit stuck[N];
  int pulses[N], bursts[N], reads[N];
  int dev_step = 4;
  int drv_viol = 0, order_viol = 0, done_cnt = 0, last_cell = 0;
  bit prev_fire = 0;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // behavioural array: step per pulse on fully selected cells, read response
  always @(negedge clk) if (!rst) begin
    int fr, fc, hr, hc;
    fr = 0; fc = 0; hr = 0; hc = 0;
    for (int i = 0; i < R; i++) begin
      if (row_drv[2*i +: 2] == 2'd2) fr++;
      if (row_drv[2*i +: 2] == 2'd1) hr++;
    end
    for (int j = 0; j < C; j++) begin
      if (col_drv[2*j +: 2] == 2'd2) fc++;
      if (col_drv[2*j +: 2] == 2'd1) hc++;
    end
    if (pulse_fire) begin
      if (fr != 1 || fc != 1 || hr != R-1 || hc != C-1) drv_viol++;
      if (rd_req) drv_viol++;
      for (int i = 0; i < R; i++)
        for (int j = 0; j < C; j++)
          if (row_drv[2*i +: 2] == 2'd2 && col_drv[2*j +: 2] == 2'd2) begin
            int k;
            k = i*C + j;
            pulses[k]++;
            if (!prev_fire) bursts[k]++;
            if (!stuck[k]) begin
              g[k] = pulse_pos ? g[k] + dev_step : g[k] - dev_step;
              if (g[k] > 255) g[k] = 255;
              if (g[k] < 0) g[k] = 0;
            end
          end
    end else if (row_drv != '0 || col_drv != '0) drv_viol++;
    prev_fire = pulse_fire;
    rd_valid = 0;
    if (rd_req) begin
      int k;
      k = int'(cur_row)*C + int'(cur_col);
      if (k < last_cell) order_viol++;
      if (reads[k] == 0 && k != last_cell + 1 && !(k == 0 && last_cell == 0)) order_viol++;
      last_cell = k;
      reads[k]++;
      rd_valid = 1;
      rd_data = W'(g[k]);
    end
    if (done) done_cnt++;
  end

  task automatic setup(int k, int init, int tgt);
    g[k] = init;
    @(negedge clk);
    tgt_we = 1; tgt_addr = AW'(k); tgt_data = W'(tgt);
    @(negedge clk);
    tgt_we = 0;
  endtask

  task automatic run(int ss, bit poke_start);
    for (int k = 0; k < N; k++) begin pulses[k] = 0; bursts[k] = 0; reads[k] = 0; end
    drv_viol = 0; order_viol = 0; done_cnt = 0; last_cell = 0;
    step_size = W'(ss);
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    if (poke_start) begin
      repeat (5) @(negedge clk);
      start = 1; @(negedge clk); start = 0;
    end
    for (int t = 0; t < 20000 && done_cnt == 0; t++) @(negedge clk);
    chk("R8 done seen", done_cnt, 1);
    chk("R8 busy low after done", int'(busy), 0);
    chk("R2 half-select pattern", drv_viol, 0);
    chk("R3 row-major order", order_viol, 0);
  endtask

  task automatic t_reset;
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 err", int'(err), 0);
    chk("R1 rd_req", int'(rd_req), 0);
    chk("R1 fire", int'(pulse_fire), 0);
    chk("R1 drive", int'(row_drv) + int'(col_drv), 0);
  endtask

  task automatic t_matched;  // R4 R5 R9 R10 with step matching device
    int tg[N] = '{50, 100, 120, 61, 8, 251};
    dev_step = 4;
    for (int k = 0; k < N; k++) stuck[k] = 0;
    setup(0, 10, 50); setup(1, 100, 100); setup(2, 200, 120);
    setup(3, 60, 61); setup(4, 0, 8); setup(5, 255, 251);
    run(4, 1);
    chk("R4 up burst pulses", pulses[0], 10);
    chk("R4 up burst count", bursts[0], 1);
    chk("R4 down burst pulses", pulses[2], 20);
    chk("R5 in-tol no pulses", pulses[3], 0);
    chk("R5 exact no pulses", pulses[1], 0);
    chk("R5 single read", reads[3], 1);
    chk("R4 min one pulse", pulses[5], 1);
    chk("R6 reread after burst", reads[0], 2);
    chk("R6 no err", int'(err), 0);
    for (int k = 0; k < N; k++) chk("R10 final conductance", g[k], (k == 3) ? 60 : tg[k]);
    repeat (30) @(negedge clk);
    chk("R9 no restart", int'(busy), 0);
    chk("R9 single done", done_cnt, 1);
  endtask

  task automatic t_oversized;  // R4 R6: step larger than device
    dev_step = 4;
    setup(0, 10, 50); setup(2, 200, 120); setup(4, 0, 8);
    run(8, 0);
    chk("R6 bursts to converge", bursts[0], 5);
    chk("R6 reads c0", reads[0], 6);
    chk("R4 total pulses c0", pulses[0], 10);
    chk("R6 c2 converged", g[2], 120);
    chk("R6 c4 bursts", bursts[4], 2);
    chk("R6 no err", int'(err), 0);
  endtask

  task automatic t_stuck;  // R6 retry limit
    dev_step = 4;
    stuck[2] = 1;
    setup(0, 50, 50); setup(2, 200, 120); setup(4, 0, 8);
    run(4, 0);
    chk("R6 stuck bursts", bursts[2], 8);
    chk("R6 stuck reads", reads[2], 9);
    chk("R6 stuck pulses", pulses[2], 160);
    chk("R6 err set", int'(err), 1);
    chk("R6 later cell done", g[4], 8);
    chk("R2 stuck cell neighbours", g[0], 50);
    stuck[2] = 0;
    repeat (3) @(negedge clk);
    chk("R6 err sticky", int'(err), 1);
  endtask

  task automatic t_zero_step;  // R4 step 0 counts as 1
    dev_step = 1;
    setup(0, 10, 13); setup(1, 5, 5); setup(2, 7, 7);
    setup(3, 9, 9); setup(4, 3, 3); setup(5, 4, 4);
    run(0, 0);
    chk("R4 zero step pulses", pulses[0], 3);
    chk("R4 zero step bursts", bursts[0], 1);
    chk("R6 err cleared on start", int'(err), 0);
    chk("R7 no pulse when idle", int'(pulse_fire), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int k = 0; k < N; k++) begin g[k] = 0; stuck[k] = 0; end
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_matched();
    t_oversized();
    t_stuck();
    t_zero_step();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule